// File: doc/BRIEF.md
# Scrambled NRZI Serial Line Coder

This block is the transmit-side channel coder of a bit-serial digital video link. An upstream word-to-bit shifter hands it one data bit per clock, together with a valid strobe. The block first randomizes each accepted bit with a self-synchronizing multiplicative scrambler whose characteristic polynomial is x^9 + x^4 + 1. It then converts the scrambled bit to NRZI, in which a one changes the line level and a zero leaves it unchanged. The result is one line bit per accepted input bit.

The scrambler feeds back from its own output. The bit shifted into its nine-stage history register is the scrambled bit, not the raw data bit. A receiver can therefore recover the data with the matching feed-forward arrangement, and it needs no separate alignment to do so. Long runs of scrambled ones leave the NRZI stage as a square wave at half the bit rate, so the line keeps the transitions that clock recovery needs.

The datapath has no control state machine. It has two registered pieces of state: the scrambler history and the NRZI line level. Both advance only on accepted bits. A synchronous reset clears everything.

Top module: `serial_line_coder`

## Requirements
- R1: While `rst` is high at a rising clock edge, all nine scrambler history stages, the line level and `line_valid` are cleared to 0. From that cleared state, a stream of zero data bits produces a line that stays at 0.
- R2: For each accepted bit (`in_valid` high), the scrambled bit is s = d XOR h4 XOR h9. Here hk is the scrambled bit accepted k accepted-bits earlier, taken as 0 when that bit precedes reset. s is then shifted into the history.
- R3: NRZI coding: on each accepted bit, the new line level is the old line level XOR s. A scrambled one toggles `line_bit`, and a scrambled zero leaves it unchanged. The new level appears on `line_bit` one clock after the input is presented.
- R4: When `in_valid` is low, neither the history nor the line level advances, and `line_bit` holds its value.
- R5: `line_valid` equals `in_valid` delayed by exactly one clock.
- R6: A run of consecutive scrambled ones makes `line_bit` toggle on every accepted bit, forming a square wave at half the bit rate.
- R7: A reset asserted mid-stream restores the same behaviour as a reset from power-up. The first bit after it is coded against an all-zero history and a line level of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Data bit from the upstream shifter |
| line_bit | output | 1 | NRZI-coded line bit (registered) |
| line_valid | output | 1 | Line bit qualifier, one clock behind `in_valid` |

## Verification
Every result of this block is due one clock after its stimulus. The scrambled bit and the new line level are both captured at the same rising edge that samples `in_valid` and `in_bit`, and `line_valid` is registered at that edge as well. The bench therefore drives each input on a falling edge and compares `line_bit` and `line_valid` with its reference model on the next falling edge. By that point exactly one rising edge has passed. For a hold cycle the model advances nothing, so the expected line bit is the previous one.

// File: rtl/line_coder_pkg.sv
package line_coder_pkg;
    // Scrambler shape: x^SCR_LEN + x^SCR_TAP + 1
    parameter int SCR_LEN = 9;
    parameter int SCR_TAP = 4;
endpackage

// File: rtl/scr_history.sv
module scr_history #(
    parameter int LEN = 9,
    parameter int TAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic din,
    output logic sbit
);
    localparam int TAP_IDX  = TAP - 1;
    localparam int LAST_IDX = LEN - 1;

    logic [LEN-1:0] hist;

    // scrambled bit from data and two delayed scrambled bits
    assign sbit = din ^ hist[TAP_IDX] ^ hist[LAST_IDX];

    always_ff @(posedge clk) begin
        if (rst)
            hist[0] <= 1'b0;
        else if (adv)
            hist[0] <= sbit;
    end

    for (genvar g = 1; g < LEN; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                hist[g] <= 1'b0;
            else if (adv)
                hist[g] <= hist[g-1];
        end
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(hist)); // R4
    AST_HIST_CLEAR: assert property (@(posedge clk)
        rst |=> (hist == '0)); // R1
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        adv |=> (hist[LEN-1:1] == $past(hist[LEN-2:0]))); // R2
endmodule

// File: rtl/nrzi_stage.sv
module nrzi_stage (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic sbit,
    output logic level
);
    always_ff @(posedge clk) begin
        if (rst)
            level <= 1'b0;
        else if (adv)
            level <= level ^ sbit;
    end

    AST_NRZI_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (adv && sbit) |=> (level != $past(level))); // R3
    AST_NRZI_KEEP: assert property (@(posedge clk) disable iff (rst)
        (adv && !sbit) |=> $stable(level)); // R3
    AST_NRZI_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(level)); // R4
endmodule

// File: rtl/serial_line_coder.sv
module serial_line_coder
    import line_coder_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic line_bit,
    output logic line_valid
);
    logic scr_bit;

    scr_history #(.LEN(SCR_LEN), .TAP(SCR_TAP)) u_scr (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_valid),
        .din  (in_bit),
        .sbit (scr_bit)
    );

    nrzi_stage u_nrzi (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_valid),
        .sbit  (scr_bit),
        .level (line_bit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            line_valid <= 1'b0;
        else
            line_valid <= in_valid;
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> line_valid); // R5
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !line_valid); // R5
    AST_RESET_OUT: assert property (@(posedge clk)
        rst |=> (!line_bit && !line_valid)); // R1
endmodule

// File: tb/serial_line_coder_bench.sv
module serial_line_coder_bench;
    localparam time CLK_HALF = 5ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic line_bit;
    logic line_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [8:0] m_hist = '0;
    logic       m_level = 1'b0;

    always #CLK_HALF clk = ~clk;

    serial_line_coder u_serial_line_coder (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .line_bit   (line_bit),
        .line_valid (line_valid)
    );

    function automatic logic ref_scr(input logic d, input logic [8:0] h);
        return d ^ h[3] ^ h[8];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // present one bit at a falling edge, compare on the next falling edge
    task automatic push(input logic v, input logic d, input string req);
        logic s;
        in_valid = v;
        in_bit   = d;
        if (v) begin
            s = ref_scr(d, m_hist);
            m_hist  = {m_hist[7:0], s};
            m_level = m_level ^ s;
        end
        @(negedge clk);
        check(req, line_bit, m_level);
        check("R5", line_valid, v);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        m_hist  = '0;
        m_level = 1'b0;
        check("R1", line_bit, 1'b0);
        check("R1", line_valid, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        logic held;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1: zeros from cleared state keep line at 0
        for (int i = 0; i < 20; i++) push(1'b1, 1'b0, "R1");

        // R3: single one after reset toggles line to 1
        do_reset();
        push(1'b1, 1'b1, "R3");
        check("R3", line_bit, 1'b1);
        // R2: impulse response through feedback taps
        for (int i = 0; i < 30; i++) push(1'b1, 1'b0, "R2");

        // R4: valid low holds output and state
        held = line_bit;
        for (int i = 0; i < 5; i++) begin
            push(1'b0, i[0], "R4");
            check("R4", line_bit, held);
        end
        for (int i = 0; i < 10; i++) push(1'b1, 1'b0, "R4");

        // R6: force scrambled ones, line must alternate
        for (int i = 0; i < 16; i++) begin
            held = line_bit;
            push(1'b1, 1'b1 ^ m_hist[3] ^ m_hist[8], "R6");
            check("R6", line_bit, ~held);
        end

        // random stream with gaps
        for (int i = 0; i < 3000; i++)
            push(($urandom % 4) != 0, $urandom % 2, "R2");

        // R7: mid-stream reset, then a single one
        do_reset();
        push(1'b1, 1'b1, "R7");
        check("R7", line_bit, 1'b1);
        for (int i = 0; i < 12; i++) push(1'b1, 1'b0, "R7");

        // R5: alternating valid pattern
        for (int i = 0; i < 40; i++)
            push(i[0] ^ i[2], $urandom % 2, "R5");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_HALF * 2 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule